// File: doc/BRIEF.md
# Reconfiguration Retry Supervisor

This block runs inside the fallback configuration of a programmable device and decides what to do after a configuration attempt ends. After reset it reads a small status word that says which image is running and whether the last attempt ended in a configuration error. On a failure it keeps a persistent failure count in one byte of external nonvolatile storage, reached over a request/acknowledge port. It reads that byte, adds one, and writes it back. It then either asks for a reconfiguration into an application image or stops retrying and waits for the host.

On a cold start, with no error recorded, the count is written back as zero and the selected application image is launched. A small host register port reports the mode and the retry count. Through the same port the host picks which of the two application images is launched, and it can clear the count and start one new launch. Any handshake that stays unanswered for too long puts the block into an error state that the host can see. The reconfiguration primitive, the flash writer and the status source are outside this block.

Top module: `recfg_retry_supervisor`

## Requirements
- R1: After reset the block makes no nonvolatile access and issues no reconfiguration request until its status read (sts_req/sts_ack) has completed.
- R2: If status bit 1 (running image is an application) is set, the block makes no nonvolatile access, issues no request, and shows bit 0 of the host status register as 1.
- R3: If status bit 0 (last attempt failed) is set, the block reads the count byte, adds one (saturating at 255), and writes the result back before any reconfiguration request.
- R4: If the updated count is below RETRY_LIMIT (default 3), exactly one reconfiguration request follows the write-back.
- R5: If the updated count is at or above RETRY_LIMIT, no request is issued and bit 1 (parked) of the host status register is set.
- R6: If neither status bit is set, the count byte is written as 0 and one reconfiguration request follows.
- R7: The request carries address 0x0E0000 when the host select bit (offset 2, bit 0) is 0 and 0x1A0000 when it is 1; the select bit resets to 1.
- R8: The host status register at offset 0 holds bit 0 = application mode, bit 1 = parked, bit 2 = error, bit 3 = launched. Offset 1 returns the current count. All of them read 0 after reset.
- R9: A handshake with no acknowledge for TIMEOUT (default 1024) cycles moves the block to the error state (status bit 2).
- R10: Writing 1 to offset 3 while parked or in error writes the count byte as 0 and launches once. The same write in any other state has no effect.
- R11: The reconfiguration request is a single-cycle pulse, given once per launch decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sts_req | output | 1 | Status read request |
| sts_ack | input | 1 | Status read acknowledge |
| sts_data | input | 2 | Status word: bit 0 failed, bit 1 application running |
| nv_req | output | 1 | Nonvolatile byte access request |
| nv_we | output | 1 | 1 = write, 0 = read |
| nv_wdata | output | 8 | Count byte to store |
| nv_ack | input | 1 | Nonvolatile access acknowledge |
| nv_rdata | input | 8 | Stored count byte, valid with nv_ack |
| rcfg_pulse | output | 1 | Reconfiguration request pulse |
| rcfg_addr | output | 24 | Image start address for the request |
| hst_wr | input | 1 | Host register write strobe |
| hst_addr | input | 2 | Host register offset |
| hst_wdata | input | 1 | Host write bit |
| hst_rdata | output | 8 | Host read data for hst_addr |

## Verification
A wrong sequencer state shows up in three places. A request pulse that appears or goes missing is visible on rcfg_pulse. A count that was skipped or written wrongly stays in the stored byte. The status and count registers show the wrong value as soon as the decision is taken, a few cycles after reset. A bad increment or threshold compare changes the stored byte and the parked bit within one handshake. A bad timeout counter is seen only after about a thousand cycles of silence, so the bench checks just below and just above that window.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int STS_W   = 2;
    localparam int ERR_BIT = 0;
    localparam int APP_BIT = 1;
    localparam int ADDR_W  = 24;
    localparam int CNT_W   = 8;

    localparam logic [ADDR_W-1:0] SAFE_IMG  = 24'h0E0000;
    localparam logic [ADDR_W-1:0] DAILY_IMG = 24'h1A0000;

    localparam logic [1:0] OFS_MODE = 2'd0;
    localparam logic [1:0] OFS_CNT  = 2'd1;
    localparam logic [1:0] OFS_SEL  = 2'd2;
    localparam logic [1:0] OFS_CLR  = 2'd3;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_STS_RD,
        ST_CNT_RD,
        ST_CNT_WR,
        ST_LAUNCH,
        ST_WAIT,
        ST_PARK,
        ST_ERR,
        ST_APP
    } seq_state_e;

    typedef struct packed {
        logic launched;
        logic failed;
        logic parked;
        logic app;
    } mode_t;

    function automatic logic [ADDR_W-1:0] image_addr(input logic sel);
        return sel ? DAILY_IMG : SAFE_IMG;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/rrs_hs_timer.sv
module rrs_hs_timer #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic done,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    assign expire = busy && !done && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !busy || done) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    tmr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (!busy || cnt <= LAST));

endmodule

// File: rtl/rrs_host_regs.sv
module rrs_host_regs
    import rrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic             wbit,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       rdata,
    output logic             sel,
    output logic             clr_cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b1;
        end else if (wr && addr == OFS_SEL) begin
            sel <= wbit;
        end
    end

    assign clr_cmd = wr && (addr == OFS_CLR) && wbit;

    always_comb begin
        unique case (addr)
            OFS_MODE: rdata = {4'b0000, mode};
            OFS_CNT:  rdata = cnt;
            OFS_SEL:  rdata = {7'b0, sel};
            default:  rdata = 8'h00;
        endcase
    end

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == OFS_SEL) |=> $stable(sel));

endmodule

// File: rtl/rrs_seq.sv
module rrs_seq
    import rrs_pkg::*;
#(
    parameter int RETRY_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    output logic             sts_req,
    input  logic             sts_ack,
    input  logic [STS_W-1:0] sts_data,
    output logic             nv_req,
    output logic             nv_we,
    output logic [CNT_W-1:0] nv_wdata,
    input  logic             nv_ack,
    input  logic [CNT_W-1:0] nv_rdata,
    input  logic             expire,
    input  logic             clr_cmd,
    output logic             rcfg_pulse,
    output mode_t            mode,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(RETRY_LIMIT);

    seq_state_e state, nxt;

    always_comb begin
        sts_req       = (state == ST_STS_RD);
        nv_req        = (state == ST_CNT_RD) || (state == ST_CNT_WR);
        nv_we         = (state == ST_CNT_WR);
        nv_wdata      = cnt_q;
        rcfg_pulse    = (state == ST_LAUNCH);
        mode.app      = (state == ST_APP);
        mode.parked   = (state == ST_PARK);
        mode.failed   = (state == ST_ERR);
        mode.launched = (state == ST_WAIT);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:   nxt = ST_STS_RD;
            ST_STS_RD: begin
                if (sts_ack) begin
                    if (sts_data[APP_BIT])      nxt = ST_APP;
                    else if (sts_data[ERR_BIT]) nxt = ST_CNT_RD;
                    else                        nxt = ST_CNT_WR;
                end else if (expire) begin
                    nxt = ST_ERR;
                end
            end
            ST_CNT_RD: begin
                if (nv_ack)      nxt = ST_CNT_WR;
                else if (expire) nxt = ST_ERR;
            end
            ST_CNT_WR: begin
                if (nv_ack)      nxt = (cnt_q < LIM) ? ST_LAUNCH : ST_PARK;
                else if (expire) nxt = ST_ERR;
            end
            ST_LAUNCH: nxt = ST_WAIT;
            ST_PARK, ST_ERR: if (clr_cmd) nxt = ST_CNT_WR;
            default:   nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_BOOT;
            cnt_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_STS_RD && sts_ack && !sts_data[APP_BIT] && !sts_data[ERR_BIT])
                cnt_q <= '0;
            else if (state == ST_CNT_RD && nv_ack)
                cnt_q <= sat_inc(nv_rdata);
            else if ((state == ST_PARK || state == ST_ERR) && clr_cmd)
                cnt_q <= '0;
        end
    end

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rcfg_pulse |=> !rcfg_pulse);

    // R5
    no_launch_over_limit_chk: assert property (@(posedge clk) disable iff (rst)
        rcfg_pulse |-> (cnt_q < LIM));

    // R1
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sts_req && nv_req));

    // R3
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (nv_req && !nv_ack && !expire) |=> (nv_req && $stable(nv_we)));

    // R2
    app_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode.app |-> (!nv_req && !rcfg_pulse));

endmodule

// File: rtl/recfg_retry_supervisor.sv
module recfg_retry_supervisor
    import rrs_pkg::*;
#(
    parameter int RETRY_LIMIT = 3,
    parameter int TIMEOUT     = 1024
) (
    input  logic        clk,
    input  logic        rst,
    output logic        sts_req,
    input  logic        sts_ack,
    input  logic [1:0]  sts_data,
    output logic        nv_req,
    output logic        nv_we,
    output logic [7:0]  nv_wdata,
    input  logic        nv_ack,
    input  logic [7:0]  nv_rdata,
    output logic        rcfg_pulse,
    output logic [23:0] rcfg_addr,
    input  logic        hst_wr,
    input  logic [1:0]  hst_addr,
    input  logic        hst_wdata,
    output logic [7:0]  hst_rdata
);
    logic             expire;
    logic             clr_cmd;
    logic             sel;
    logic [CNT_W-1:0] cnt_q;
    mode_t            mode;
    logic             hs_busy;
    logic             hs_done;

    assign hs_busy   = sts_req | nv_req;
    assign hs_done   = (sts_req & sts_ack) | (nv_req & nv_ack);
    assign rcfg_addr = image_addr(sel);

    rrs_hs_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .busy   (hs_busy),
        .done   (hs_done),
        .expire (expire)
    );

    rrs_seq #(.RETRY_LIMIT(RETRY_LIMIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sts_req    (sts_req),
        .sts_ack    (sts_ack),
        .sts_data   (sts_data),
        .nv_req     (nv_req),
        .nv_we      (nv_we),
        .nv_wdata   (nv_wdata),
        .nv_ack     (nv_ack),
        .nv_rdata   (nv_rdata),
        .expire     (expire),
        .clr_cmd    (clr_cmd),
        .rcfg_pulse (rcfg_pulse),
        .mode       (mode),
        .cnt_q      (cnt_q)
    );

    rrs_host_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (hst_wr),
        .addr    (hst_addr),
        .wbit    (hst_wdata),
        .mode    (mode),
        .cnt     (cnt_q),
        .rdata   (hst_rdata),
        .sel     (sel),
        .clr_cmd (clr_cmd)
    );

endmodule

// File: tb/recfg_retry_supervisor_test.sv
module recfg_retry_supervisor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sts_req, sts_ack = 1'b0;
    logic [1:0]  sts_data = 2'b00;
    logic        nv_req, nv_we, nv_ack = 1'b0;
    logic [7:0]  nv_wdata, nv_rdata = 8'h00;
    logic        rcfg_pulse;
    logic [23:0] rcfg_addr;
    logic        hst_wr = 1'b0;
    logic [1:0]  hst_addr = 2'd0;
    logic        hst_wdata = 1'b0;
    logic [7:0]  hst_rdata;

    int total = 0;
    int bad   = 0;
    logic       sts_en = 1'b1;
    logic       nv_en  = 1'b1;
    logic [7:0] nv_mem = 8'h00;
    int          pulses = 0;
    logic [23:0] last_addr = '0;
    logic [7:0]  mem_at_pulse = '0;
    logic        early_bad = 1'b0;
    logic        sts_done = 1'b0;

    always #5 clk = ~clk;

    recfg_retry_supervisor uut (
        .clk(clk), .rst(rst),
        .sts_req(sts_req), .sts_ack(sts_ack), .sts_data(sts_data),
        .nv_req(nv_req), .nv_we(nv_we), .nv_wdata(nv_wdata),
        .nv_ack(nv_ack), .nv_rdata(nv_rdata),
        .rcfg_pulse(rcfg_pulse), .rcfg_addr(rcfg_addr),
        .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata)
    );

    // responders for the status and nonvolatile ports
    initial begin
        forever begin
            @(negedge clk);
            if (sts_ack) sts_ack = 1'b0;
            else if (sts_req && sts_en) begin sts_ack = 1'b1; sts_done = 1'b1; end
            if (nv_ack) nv_ack = 1'b0;
            else if (nv_req && nv_en) begin
                if (nv_we) nv_mem = nv_wdata;
                nv_rdata = nv_mem;
                nv_ack = 1'b1;
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst) begin
            pulses = 0;
            sts_done = 1'b0;
            early_bad = 1'b0;
        end else begin
            if (!sts_done && (nv_req || rcfg_pulse)) early_bad = 1'b1;
            if (rcfg_pulse) begin
                pulses = pulses + 1;
                last_addr = rcfg_addr;
                mem_at_pulse = nv_mem;
            end
        end
    end

    initial begin
        #1_500_000;
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic d);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        hst_addr = a;
        #1;
        d = hst_rdata;
    endtask

    task automatic do_reset(input logic [1:0] sd, input logic [7:0] mem);
        rst = 1'b1;
        sts_data = sd;
        nv_mem = mem;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  sts;
        logic [7:0]  mem;
        logic        sel;
        logic [1:0]  npulse;
        logic [23:0] addr;
        logic [7:0]  nv;
        logic [3:0]  stat;
        logic [7:0]  cnt;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{2'b00, 8'd7,   1'b1, 2'd1, 24'h1A0000, 8'd0,   4'b1000, 8'd0},   // R6 R7
        '{2'b00, 8'd9,   1'b0, 2'd1, 24'h0E0000, 8'd0,   4'b1000, 8'd0},   // R6 R7
        '{2'b01, 8'd0,   1'b1, 2'd1, 24'h1A0000, 8'd1,   4'b1000, 8'd1},   // R3 R4
        '{2'b01, 8'd1,   1'b0, 2'd1, 24'h0E0000, 8'd2,   4'b1000, 8'd2},   // R3 R4
        '{2'b01, 8'd2,   1'b1, 2'd0, 24'h000000, 8'd3,   4'b0010, 8'd3},   // R5
        '{2'b01, 8'd5,   1'b0, 2'd0, 24'h000000, 8'd6,   4'b0010, 8'd6},   // R5
        '{2'b01, 8'd255, 1'b1, 2'd0, 24'h000000, 8'd255, 4'b0010, 8'd255}, // R3 saturate
        '{2'b10, 8'd9,   1'b1, 2'd0, 24'h000000, 8'd9,   4'b0001, 8'd0}    // R2
    };

    initial begin
        logic [7:0] rd;

        // reset state
        repeat (3) @(negedge clk);
        chk("R1 sts_req in reset", {31'b0, sts_req}, 32'd0);
        chk("R1 nv_req in reset", {31'b0, nv_req}, 32'd0);
        chk("R11 pulse in reset", {31'b0, rcfg_pulse}, 32'd0);
        host_rd(2'd0, rd); chk("R8 mode reset", {24'b0, rd}, 32'd0);
        host_rd(2'd1, rd); chk("R8 count reset", {24'b0, rd}, 32'd0);
        host_rd(2'd2, rd); chk("R7 select reset", {24'b0, rd}, 32'd1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            do_reset(TABLE[i].sts, TABLE[i].mem);
            host_wr(2'd2, TABLE[i].sel);
            repeat (30) @(negedge clk);
            chk("R1 nothing before status", {31'b0, early_bad}, 32'd0);
            chk("R4 R5 R11 pulse count", pulses, {30'b0, TABLE[i].npulse});
            if (TABLE[i].npulse != 0) begin
                chk("R7 address", {8'b0, last_addr}, {8'b0, TABLE[i].addr});
                chk("R3 R6 written before launch", {24'b0, mem_at_pulse}, {24'b0, TABLE[i].nv});
            end
            chk("R3 R6 stored count", {24'b0, nv_mem}, {24'b0, TABLE[i].nv});
            host_rd(2'd0, rd); chk("R8 mode", {24'b0, rd}, {28'b0, TABLE[i].stat});
            host_rd(2'd1, rd); chk("R8 count", {24'b0, rd}, {24'b0, TABLE[i].cnt});
        end

        // clear ignored while launched
        do_reset(2'b00, 8'd3);
        repeat (30) @(negedge clk);
        nv_mem = 8'd4;
        host_wr(2'd3, 1'b1);
        repeat (20) @(negedge clk);
        chk("R10 clear ignored pulses", pulses, 32'd1);
        chk("R10 clear ignored store", {24'b0, nv_mem}, 32'd4);

        // clear and retry from parked
        do_reset(2'b01, 8'd2);
        repeat (30) @(negedge clk);
        host_rd(2'd0, rd); chk("R5 parked", {24'b0, rd}, 32'h02);
        host_wr(2'd2, 1'b0);
        host_wr(2'd3, 1'b1);
        repeat (20) @(negedge clk);
        chk("R10 retry pulse", pulses, 32'd1);
        chk("R10 retry addr", {8'b0, last_addr}, 32'h0E0000);
        chk("R10 retry store", {24'b0, nv_mem}, 32'd0);
        host_rd(2'd0, rd); chk("R10 launched", {24'b0, rd}, 32'h08);

        // timeout on status port
        sts_en = 1'b0;
        do_reset(2'b01, 8'd0);
        repeat (1000) @(negedge clk);
        host_rd(2'd0, rd); chk("R9 no error early", {24'b0, rd}, 32'h00);
        repeat (40) @(negedge clk);
        host_rd(2'd0, rd); chk("R9 status timeout", {24'b0, rd}, 32'h04);
        sts_en = 1'b1;

        // timeout on nonvolatile port, then clear from error
        nv_en = 1'b0;
        do_reset(2'b01, 8'd1);
        repeat (1000) @(negedge clk);
        host_rd(2'd0, rd); chk("R9 nv no error early", {24'b0, rd}, 32'h00);
        repeat (40) @(negedge clk);
        host_rd(2'd0, rd); chk("R9 nv timeout", {24'b0, rd}, 32'h04);
        chk("R9 no pulse on timeout", pulses, 32'd0);
        nv_en = 1'b1;
        host_wr(2'd3, 1'b1);
        repeat (20) @(negedge clk);
        chk("R10 retry from error pulse", pulses, 32'd1);
        chk("R10 retry from error store", {24'b0, nv_mem}, 32'd0);
        chk("R7 default select addr", {8'b0, last_addr}, 32'h1A0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule